// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed Sequence

This block is a supervisor that must be refreshed ("fed") periodically by software. A programmable time-out constant is copied into a down-counter whenever software writes the two-byte key pair 0xAA then 0x55 to the feed register. The counter moves one step for every four clocks of the block clock. If it runs out while the watchdog is armed, or if software breaks an open feed sequence with any other register access, the block flags a time-out and raises either a reset request or an interrupt, chosen by a mode bit.

Arming is deliberately two-stage: setting the enable bit only permits arming, and the watchdog becomes live at the first completed feed after that. The enable bit cannot be cleared by software. A single clock drives both the register interface and the counter.

Register map (byte offsets on `bus_addr`): 0x0 mode, 0x4 time-out constant, 0x8 feed (write-only, reads 0), 0xC counter value (read-only). Mode bits: bit 0 enable, bit 1 reset-select, bit 2 time-out flag.

Top module: `wdog_top`

## Requirements
- R1: After reset the constant and counter value both read 0x000000FF, the mode register reads 0, and `irq` and `rst_req` are low.
- R2: A write to offset 0x4 stores the written value, except that any value below 0xFF is stored as 0x000000FF.
- R3: Writing 0xAA and then 0x55 to offset 0x8 loads the counter with the time-out constant.
- R4: Setting mode bit 0 without a following complete feed leaves the counter stopped at its value and raises no output, however long the wait.
- R5: While not armed, breaking a feed sequence (0xAA followed by another access) raises neither `irq` nor `rst_req`.
- R6: Once armed with constant C, if no feed occurs, the time-out outputs rise on the (C+1)*4+1-th clock edge after the edge that took the 0x55 write.
- R7: Once armed, an access that follows a 0xAA feed write and is not a 0x55 feed write causes a fault whose output rises on the second clock edge after that access.
- R8: On a time-out or fault, mode bit 2 is set; `rst_req` rises if mode bit 1 is 1, otherwise `irq` rises and `rst_req` stays low.
- R9: Once mode bit 0 is set, writing 0 to it has no effect; only the reset input clears it.
- R10: Only bits 7:0 of a feed write are compared with the keys; upper bits are ignored.
- R11: Writing 1 to mode bit 2 clears the flag and `irq`; `rst_req` stays high until reset.
- R12: While armed, the counter value drops by one every four clocks, the first step on the fourth edge after the feed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers and counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Time-out interrupt (reset-select clear) |
| rst_req | output | 1 | Sticky reset request (reset-select set) |

## Verification
The constant register is driven with a table of values straddling the 0xFF floor (zero, one, just below, exactly at, just above, all ones), which separates a correct clamp from an off-by-one compare or a missing clamp. The feed path is tried with clean key pairs, keys carrying junk in the upper bits, a broken pair before arming and a broken pair after arming, which distinguishes arming on enable alone, full-width key compares and ignoring errors at the wrong time. Time-outs are observed edge-exactly under both settings of the reset-select bit, so a wrong prescale ratio, a missing terminal step or swapped routing each shows up as a one-edge or wrong-pin difference.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned ADDR_W = 4;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_MODE  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_TC    = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_FEED  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 4'hC;

    // mode register bit positions
    localparam int unsigned MB_EN   = 0;
    localparam int unsigned MB_RSEL = 1;
    localparam int unsigned MB_FLAG = 2;

    localparam logic [7:0] KEY_OPEN  = 8'hAA;
    localparam logic [7:0] KEY_CLOSE = 8'h55;

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] ph_d, ph_q;

    assign tick = run && (ph_q == LAST);

    always_comb begin
        ph_d = ph_q;
        if (clear) begin
            ph_d = '0;
        end else if (run) begin
            ph_d = tick ? '0 : ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       feed_wr,
    input  logic [7:0] key,
    output logic       done,
    output logic       broken
);
    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        done   = 1'b0;
        broken = 1'b0;
        if (acc) begin
            if (open_q) begin
                open_d = 1'b0;
                if (feed_wr && key == KEY_CLOSE) done   = 1'b1;
                else                             broken = 1'b1;
            end else if (feed_wr && key == KEY_OPEN) begin
                open_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_d;
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned W     = 32,
    parameter logic [W-1:0] INIT = 'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] reload,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] v_d, v_q;

    assign value   = v_q;
    assign expired = step && (v_q == '0);

    always_comb begin
        v_d = v_q;
        if (load || expired) v_d = reload;
        else if (step)       v_d = v_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= INIT;
        else        v_q <= v_d;
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int unsigned  DATA_W   = 32,
    parameter int unsigned  PRESCALE = 4,
    parameter logic [31:0]  TC_MIN   = 32'h0000_00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    localparam logic [DATA_W-1:0] FLOOR = DATA_W'(TC_MIN);

    typedef struct packed {
        logic              en;
        logic              rsel;
        logic              flag;
        logic              irq;
        logic              rst_req;
        logic              armed;
        logic              ev;
        logic [DATA_W-1:0] tc;
    } state_t;

    state_t st_d, st_q;

    logic              wr_acc;
    logic              feed_done, feed_broken;
    logic              tick, zero_hit;
    logic [DATA_W-1:0] cnt;

    assign wr_acc = bus_sel && bus_wr;

    wdog_feed_seq i_feed (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (bus_sel),
        .feed_wr (wr_acc && bus_addr == OFS_FEED),
        .key     (bus_wdata[7:0]),
        .done    (feed_done),
        .broken  (feed_broken)
    );

    wdog_prescale #(.DIV(PRESCALE)) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.armed),
        .clear (feed_done),
        .tick  (tick)
    );

    wdog_counter #(.W(DATA_W), .INIT(FLOOR)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (feed_done),
        .reload  (st_q.tc),
        .step    (tick),
        .value   (cnt),
        .expired (zero_hit)
    );

    always_comb begin
        st_d = st_q;
        if (wr_acc && bus_addr == OFS_MODE) begin
            st_d.en   = st_q.en | bus_wdata[MB_EN];
            st_d.rsel = bus_wdata[MB_RSEL];
            if (bus_wdata[MB_FLAG]) begin
                st_d.flag = 1'b0;
                st_d.irq  = 1'b0;
            end
        end
        if (wr_acc && bus_addr == OFS_TC) begin
            st_d.tc = (bus_wdata < FLOOR) ? FLOOR : bus_wdata;
        end
        if (feed_done && st_q.en) st_d.armed = 1'b1;
        // fault or expiry is staged one cycle before it reaches the pins
        st_d.ev = st_q.armed && (feed_broken || zero_hit);
        if (st_q.ev) begin
            st_d.flag = 1'b1;
            if (st_q.rsel) st_d.rst_req = 1'b1;
            else           st_d.irq     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.tc <= FLOOR;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE: begin
                bus_rdata[MB_EN]   = st_q.en;
                bus_rdata[MB_RSEL] = st_q.rsel;
                bus_rdata[MB_FLAG] = st_q.flag;
            end
            OFS_TC:    bus_rdata = st_q.tc;
            OFS_COUNT: bus_rdata = cnt;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq     = st_q.irq;
    assign rst_req = st_q.rst_req;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter logic [31:0] TC_MIN = 32'h0000_00FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              rst_req,
    input logic              armed,
    input logic              en,
    input logic              rsel,
    input logic [DATA_W-1:0] tc,
    input logic [DATA_W-1:0] cnt,
    input logic              feed_done,
    input logic              feed_broken
);
    p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_TC && bus_wdata < DATA_W'(TC_MIN))
        |=> tc == DATA_W'(TC_MIN));

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        feed_done |=> cnt == tc);

    p_arm_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> en);

    p_fault_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && feed_broken) |=> ##1 (irq || rst_req));

    p_route_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(rsel));

    p_route_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !$past(rsel));

    p_sticky_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);

    p_sticky_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
endmodule

bind wdog_top wdog_checker #(.DATA_W(DATA_W), .TC_MIN(TC_MIN)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .irq         (irq),
    .rst_req     (rst_req),
    .armed       (st_q.armed),
    .en          (st_q.en),
    .rsel        (st_q.rsel),
    .tc          (st_q.tc),
    .cnt         (cnt),
    .feed_done   (feed_done),
    .feed_broken (feed_broken)
);

// File: tb/test_wdog_top.sv
module test_wdog_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wdog_top i_wdog_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    // {written value, value expected back}
    localparam logic [63:0] TC_VEC [7] = '{
        {32'h0000_0000, 32'h0000_00FF},
        {32'h0000_0001, 32'h0000_00FF},
        {32'h0000_00FE, 32'h0000_00FF},
        {32'h0000_00FF, 32'h0000_00FF},
        {32'h0000_0100, 32'h0000_0100},
        {32'h1234_5678, 32'h1234_5678},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_access(input logic [3:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        peek(4'h0, v); check("R1 mode", v, 32'h0);
        peek(4'h4, v); check("R1 constant", v, 32'hFF);
        peek(4'hC, v); check("R1 counter", v, 32'hFF);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);

        // R2 clamp table
        for (int i = 0; i < 7; i++) begin
            wr(4'h4, TC_VEC[i][63:32]);
            peek(4'h4, v);
            check("R2 clamp", v, TC_VEC[i][31:0]);
        end

        // R4, R5: enable only, broken sequence before arming
        do_reset();
        wr(4'h0, 32'h1);
        wr(4'h8, 32'hAA);
        rd_access(4'h0);
        repeat (2) @(negedge clk);
        check("R5 irq", {31'b0, irq}, 32'h0);
        check("R5 rst_req", {31'b0, rst_req}, 32'h0);
        repeat (1100) @(negedge clk);
        peek(4'hC, v); check("R4 counter held", v, 32'hFF);
        check("R4 irq", {31'b0, irq}, 32'h0);

        // R3, R10, R12: upper-bit junk on keys, reload and stepping
        wr(4'h4, 32'h100);
        wr(4'h8, 32'hFFFF_FFAA);
        wr(4'h8, 32'h1234_5655);
        peek(4'hC, v); check("R3 R10 reload", v, 32'h100);
        repeat (3) @(negedge clk);
        peek(4'hC, v); check("R12 before step", v, 32'h100);
        @(negedge clk);
        peek(4'hC, v); check("R12 first step", v, 32'hFF);
        repeat (4) @(negedge clk);
        peek(4'hC, v); check("R12 second step", v, 32'hFE);

        // R9 enable cannot be cleared
        wr(4'h0, 32'h0);
        peek(4'h0, v); check("R9 enable sticky", v & 32'h1, 32'h1);

        // R6, R8 interrupt route, R11 flag clear
        do_reset();
        wr(4'h0, 32'h1);
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'h55);
        repeat (1024) @(negedge clk);
        check("R6 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R6 irq at expiry", {31'b0, irq}, 32'h1);
        check("R8 no rst_req", {31'b0, rst_req}, 32'h0);
        peek(4'h0, v); check("R8 flag", v & 32'h4, 32'h4);
        wr(4'h0, 32'h5);
        check("R11 irq cleared", {31'b0, irq}, 32'h0);
        peek(4'h0, v); check("R11 flag cleared", v & 32'h4, 32'h0);

        // R7, R8 reset route, R11 reset request held
        do_reset();
        wr(4'h0, 32'h3);
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'h55);
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'h66);
        check("R7 one edge after", {31'b0, rst_req}, 32'h0);
        @(negedge clk);
        check("R7 second edge", {31'b0, rst_req}, 32'h1);
        check("R8 no irq", {31'b0, irq}, 32'h0);
        wr(4'h0, 32'h7);
        check("R11 rst_req held", {31'b0, rst_req}, 32'h1);
        peek(4'h0, v); check("R11 flag cleared", v & 32'h4, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule